// File: doc/BRIEF.md
# Privileged Register Access Arbiter

This block settles what happens when software issues a coprocessor-style system register instruction aimed at one virtualizable interrupt control register, the register that sets how interrupt priorities split into a preemption part and a subpriority part. It compares the decoded instruction fields with the one encoding it owns. It reads the current privilege level, which higher levels exist and are active, whether level 3 runs in 32-bit mode, monitor-mode status, and a set of trap, routing and interface-enable controls. From these it picks one outcome: undefined instruction, trap to level 2, trap to level 3, access to the virtual copy, or access to the physical copy.

The register storage lives elsewhere. The outcome strobes select which copy the storage side uses, or which exception the core raises. The block applies the same decision to reads and writes and carries the direction bit along with the result. The decision logic is combinational. The outcome, the trap code and the direction are registered once, so they appear one clock after the inputs are presented.

Top module: `sysreg_access_arbiter`

## Requirements
- R1: Only the encoding coprocessor 15, opc1 0, CRn 12, CRm 8, opc2 3 produces an outcome. When any field differs, all five outcome outputs are 0 on the following clock.
- R2: Outputs are registered. They reflect the inputs sampled at the previous rising edge. At most one of res_undef, res_trap_l2, res_trap_l3, res_virt, res_phys is high, and exactly one is high when the encoding matches.
- R3: A matching access at level 0 (cur_lvl = 0) is always undefined.
- R4: At level 1 the first four checks run in this order. (a) Level-3 routing plus dbg_undef_early gives undefined. (b) cp_group_trap gives a trap to level 2. (c) iface_en[0] = 0 gives undefined. (d) trap_all_g0 gives a trap to level 2.
- R5: If level 1 passes R4, then fiq_virt gives the virtual copy. Otherwise, level-3 routing gives undefined when dbg_undef_late is set and a trap to level 3 when it is not. Otherwise the result is the physical copy.
- R6: Level-3 routing means has_l3 = 1 and fiq_route_l3 = 1. At level 1 it is ignored when l3_narrow = 1 and in_monitor = 1.
- R7: At level 2 the checks run in this order. (a) Level-3 routing plus dbg_undef_early gives undefined. (b) iface_en[1] = 0 gives undefined. (c) Level-3 routing gives undefined or a trap to level 3, chosen by dbg_undef_late. (d) Otherwise the physical copy. At level 2, in_monitor has no effect.
- R8: At level 3, iface_en[2] = 0 gives undefined. Otherwise the result is the physical copy.
- R9: cp_group_trap, trap_all_g0 and fiq_virt take effect only when level 2 is enabled, meaning has_l2 = 1 and l2_active = 1.
- R10: res_code is 3 whenever a trap output is high, and 0 otherwise.
- R11: res_wr equals acc_wr from the previous clock, whatever the outcome.
- R12: While rst is high at a rising edge, all outputs are cleared to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_cp | input | 4 | Coprocessor number of the access |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wr | input | 1 | Direction, 1 = write |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| has_l2 | input | 1 | Level 2 implemented |
| l2_active | input | 1 | Level 2 active for the current state |
| has_l3 | input | 1 | Level 3 implemented |
| l3_narrow | input | 1 | Level 3 runs in 32-bit mode |
| in_monitor | input | 1 | Processor is in monitor mode |
| fiq_route_l3 | input | 1 | Fast interrupts routed to level 3 |
| dbg_undef_early | input | 1 | Secure-debug undefined, high-priority form |
| dbg_undef_late | input | 1 | Secure-debug undefined, low-priority form |
| cp_group_trap | input | 1 | Trap of the coprocessor group to level 2 |
| trap_all_g0 | input | 1 | Trap all group-0 accesses to level 2 |
| fiq_virt | input | 1 | Fast-interrupt virtualization |
| iface_en | input | 3 | Register-interface enable per level, bit 0 = level 1 |
| res_undef | output | 1 | Outcome: undefined |
| res_trap_l2 | output | 1 | Outcome: trap to level 2 |
| res_trap_l3 | output | 1 | Outcome: trap to level 3 |
| res_virt | output | 1 | Outcome: virtual copy accessed |
| res_phys | output | 1 | Outcome: physical copy accessed |
| res_code | output | 6 | Trap syndrome code |
| res_wr | output | 1 | Registered direction |

## Verification
The only state is the output register, so any wrong decision shows at the ports exactly one clock after the offending input vector, with nothing to drain. A misordered check or a missing enable qualifier shows up as the wrong outcome strobe for particular control combinations. Sweeping every combination of level and control bits therefore exposes it. A corrupted encoding compare shows as a strobe on a foreign encoding, or as silence on the owned one.

// File: rtl/sysreg_arb_pkg.sv
package sysreg_arb_pkg;
  localparam int LVL_W = 2;
  localparam int EN_W  = 3;

  typedef enum logic [2:0] {
    VD_NONE  = 3'd0,
    VD_UNDEF = 3'd1,
    VD_TRAP2 = 3'd2,
    VD_TRAP3 = 3'd3,
    VD_VIRT  = 3'd4,
    VD_PHYS  = 3'd5
  } verdict_t;

  typedef struct packed {
    logic            has_l2;
    logic            l2_active;
    logic            has_l3;
    logic            l3_narrow;
    logic            in_monitor;
    logic            fiq_route_l3;
    logic            dbg_undef_early;
    logic            dbg_undef_late;
    logic            cp_group_trap;
    logic            trap_all_g0;
    logic            fiq_virt;
    logic [EN_W-1:0] iface_en;
  } ctl_t;
endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match #(
  parameter int CP_W   = 4,
  parameter int OP1_W  = 3,
  parameter int CRN_W  = 4,
  parameter int CRM_W  = 4,
  parameter int OP2_W  = 3,
  parameter int SEL_CP  = 15,
  parameter int SEL_OP1 = 0,
  parameter int SEL_CRN = 12,
  parameter int SEL_CRM = 8,
  parameter int SEL_OP2 = 3
) (
  input  logic [CP_W-1:0]  cp,
  input  logic [OP1_W-1:0] opc1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] opc2,
  output logic             hit
);
  localparam logic [CP_W-1:0]  K_CP  = CP_W'(SEL_CP);
  localparam logic [OP1_W-1:0] K_OP1 = OP1_W'(SEL_OP1);
  localparam logic [CRN_W-1:0] K_CRN = CRN_W'(SEL_CRN);
  localparam logic [CRM_W-1:0] K_CRM = CRM_W'(SEL_CRM);
  localparam logic [OP2_W-1:0] K_OP2 = OP2_W'(SEL_OP2);

  always_comb begin
    hit = (cp == K_CP) && (opc1 == K_OP1) && (crn == K_CRN) &&
          (crm == K_CRM) && (opc2 == K_OP2);
  end
endmodule

// File: rtl/lvl_rule_chain.sv
module lvl_rule_chain
  import sysreg_arb_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  input  ctl_t             ctl,
  output verdict_t         verdict
);
  logic l2_on;
  logic route_any;
  logic route_l1;
  verdict_t route_tail;

  always_comb begin
    l2_on      = ctl.has_l2 & ctl.l2_active;
    route_any  = ctl.has_l3 & ctl.fiq_route_l3;
    route_l1   = route_any & ~(ctl.l3_narrow & ctl.in_monitor);
    route_tail = ctl.dbg_undef_late ? VD_UNDEF : VD_TRAP3;
  end

  always_comb begin
    verdict = VD_UNDEF;
    unique case (lvl)
      2'd0: verdict = VD_UNDEF;
      2'd1: begin
        if (route_l1 && ctl.dbg_undef_early)        verdict = VD_UNDEF;
        else if (l2_on && ctl.cp_group_trap)        verdict = VD_TRAP2;
        else if (!ctl.iface_en[0])                  verdict = VD_UNDEF;
        else if (l2_on && ctl.trap_all_g0)          verdict = VD_TRAP2;
        else if (l2_on && ctl.fiq_virt)             verdict = VD_VIRT;
        else if (route_l1)                          verdict = route_tail;
        else                                        verdict = VD_PHYS;
      end
      2'd2: begin
        if (route_any && ctl.dbg_undef_early)       verdict = VD_UNDEF;
        else if (!ctl.iface_en[1])                  verdict = VD_UNDEF;
        else if (route_any)                         verdict = route_tail;
        else                                        verdict = VD_PHYS;
      end
      default: verdict = ctl.iface_en[2] ? VD_PHYS : VD_UNDEF;
    endcase
  end
endmodule

// File: rtl/verdict_reg.sv
module verdict_reg
  import sysreg_arb_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int TRAP_CODE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  verdict_t          verdict_in,
  input  logic              wr_in,
  output logic              q_undef,
  output logic              q_trap2,
  output logic              q_trap3,
  output logic              q_virt,
  output logic              q_phys,
  output logic [CODE_W-1:0] q_code,
  output logic              q_wr
);
  localparam logic [CODE_W-1:0] K_CODE = CODE_W'(TRAP_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_undef <= 1'b0;
      q_trap2 <= 1'b0;
      q_trap3 <= 1'b0;
      q_virt  <= 1'b0;
      q_phys  <= 1'b0;
      q_code  <= '0;
      q_wr    <= 1'b0;
    end else begin
      q_undef <= (verdict_in == VD_UNDEF);
      q_trap2 <= (verdict_in == VD_TRAP2);
      q_trap3 <= (verdict_in == VD_TRAP3);
      q_virt  <= (verdict_in == VD_VIRT);
      q_phys  <= (verdict_in == VD_PHYS);
      q_code  <= ((verdict_in == VD_TRAP2) || (verdict_in == VD_TRAP3)) ? K_CODE : '0;
      q_wr    <= wr_in;
    end
  end
endmodule

// File: rtl/sysreg_access_arbiter.sv
module sysreg_access_arbiter
  import sysreg_arb_pkg::*;
#(
  parameter int CP_W      = 4,
  parameter int OP1_W     = 3,
  parameter int CRN_W     = 4,
  parameter int CRM_W     = 4,
  parameter int OP2_W     = 3,
  parameter int CODE_W    = 6,
  parameter int TRAP_CODE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CP_W-1:0]   acc_cp,
  input  logic [OP1_W-1:0]  acc_opc1,
  input  logic [CRN_W-1:0]  acc_crn,
  input  logic [CRM_W-1:0]  acc_crm,
  input  logic [OP2_W-1:0]  acc_opc2,
  input  logic              acc_wr,
  input  logic [1:0]        cur_lvl,
  input  logic              has_l2,
  input  logic              l2_active,
  input  logic              has_l3,
  input  logic              l3_narrow,
  input  logic              in_monitor,
  input  logic              fiq_route_l3,
  input  logic              dbg_undef_early,
  input  logic              dbg_undef_late,
  input  logic              cp_group_trap,
  input  logic              trap_all_g0,
  input  logic              fiq_virt,
  input  logic [2:0]        iface_en,
  output logic              res_undef,
  output logic              res_trap_l2,
  output logic              res_trap_l3,
  output logic              res_virt,
  output logic              res_phys,
  output logic [CODE_W-1:0] res_code,
  output logic              res_wr
);
  logic     hit;
  ctl_t     ctl;
  verdict_t rule_v;
  verdict_t final_v;

  sysreg_enc_match #(
    .CP_W(CP_W), .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W)
  ) u_match (
    .cp(acc_cp), .opc1(acc_opc1), .crn(acc_crn), .crm(acc_crm), .opc2(acc_opc2),
    .hit(hit)
  );

  always_comb begin
    ctl = '{has_l2: has_l2, l2_active: l2_active, has_l3: has_l3,
            l3_narrow: l3_narrow, in_monitor: in_monitor,
            fiq_route_l3: fiq_route_l3, dbg_undef_early: dbg_undef_early,
            dbg_undef_late: dbg_undef_late, cp_group_trap: cp_group_trap,
            trap_all_g0: trap_all_g0, fiq_virt: fiq_virt, iface_en: iface_en};
  end

  lvl_rule_chain u_chain (
    .lvl(cur_lvl), .ctl(ctl), .verdict(rule_v)
  );

  always_comb final_v = hit ? rule_v : VD_NONE;

  verdict_reg #(.CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_reg (
    .clk(clk), .rst(rst), .verdict_in(final_v), .wr_in(acc_wr),
    .q_undef(res_undef), .q_trap2(res_trap_l2), .q_trap3(res_trap_l3),
    .q_virt(res_virt), .q_phys(res_phys), .q_code(res_code), .q_wr(res_wr)
  );

  // One cycle after any non-reset edge the output register holds a decision.
  logic warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  logic [4:0] outs;
  always_comb outs = {res_undef, res_trap_l2, res_trap_l3, res_virt, res_phys};

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst || !warm)
    $onehot0(outs)); // R2
  AST_HIT_GIVES_ONE: assert property (@(posedge clk) disable iff (rst || !warm)
    $past(hit) |-> ($countones(outs) == 1)); // R2
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst || !warm)
    !$past(hit) |-> (outs == 5'b0)); // R1
  AST_USER_UNDEF: assert property (@(posedge clk) disable iff (rst || !warm)
    ($past(hit) && ($past(cur_lvl) == 2'd0)) |-> res_undef); // R3
  AST_TOP_ENABLED: assert property (@(posedge clk) disable iff (rst || !warm)
    ($past(hit) && ($past(cur_lvl) == 2'd3) && $past(iface_en[2])) |-> res_phys); // R8
  AST_TRAP_CODE: assert property (@(posedge clk) disable iff (rst || !warm)
    (res_trap_l2 || res_trap_l3) |-> (res_code == CODE_W'(TRAP_CODE))); // R10
  AST_NO_TRAP_NO_CODE: assert property (@(posedge clk) disable iff (rst || !warm)
    !(res_trap_l2 || res_trap_l3) |-> (res_code == '0)); // R10
  AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !warm)
    res_wr == $past(acc_wr)); // R11
  AST_VIRT_NEEDS_L2: assert property (@(posedge clk) disable iff (rst || !warm)
    res_virt |-> $past(has_l2 && l2_active)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) && warm == 1'b0 && $past(warm) == 1'b0 |-> (outs == 5'b0 && res_wr == 1'b0)); // R12
endmodule

// File: tb/sysreg_access_arbiter_tb.sv
module sysreg_access_arbiter_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] acc_cp = 4'd15;
  logic [2:0] acc_opc1 = 3'd0;
  logic [3:0] acc_crn = 4'd12;
  logic [3:0] acc_crm = 4'd8;
  logic [2:0] acc_opc2 = 3'd3;
  logic       acc_wr = 1'b1;
  logic [1:0] cur_lvl = 2'd3;
  logic has_l2 = 0, l2_active = 0, has_l3 = 0, l3_narrow = 0, in_monitor = 0;
  logic fiq_route_l3 = 0, dbg_undef_early = 0, dbg_undef_late = 0;
  logic cp_group_trap = 0, trap_all_g0 = 0, fiq_virt = 0;
  logic [2:0] iface_en = 3'b111;
  logic res_undef, res_trap_l2, res_trap_l3, res_virt, res_phys, res_wr;
  logic [5:0] res_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_access_arbiter u_dut (
    .clk, .rst, .acc_cp, .acc_opc1, .acc_crn, .acc_crm, .acc_opc2, .acc_wr,
    .cur_lvl, .has_l2, .l2_active, .has_l3, .l3_narrow, .in_monitor,
    .fiq_route_l3, .dbg_undef_early, .dbg_undef_late, .cp_group_trap,
    .trap_all_g0, .fiq_virt, .iface_en,
    .res_undef, .res_trap_l2, .res_trap_l3, .res_virt, .res_phys,
    .res_code, .res_wr
  );

  // Outcome encoding used by the bench: {undef, trap2, trap3, virt, phys}
  localparam logic [4:0] E_UNDEF = 5'b10000;
  localparam logic [4:0] E_TRAP2 = 5'b01000;
  localparam logic [4:0] E_TRAP3 = 5'b00100;
  localparam logic [4:0] E_VIRT  = 5'b00010;
  localparam logic [4:0] E_PHYS  = 5'b00001;

  function automatic logic [4:0] expect_outcome();
    logic l2ok, rt, rt1;
    l2ok = has_l2 && l2_active;
    rt   = has_l3 && fiq_route_l3;
    rt1  = rt && !(l3_narrow && in_monitor);
    if (cur_lvl == 2'd0) return E_UNDEF;
    if (cur_lvl == 2'd3) return iface_en[2] ? E_PHYS : E_UNDEF;
    if (cur_lvl == 2'd2) begin
      if (rt && dbg_undef_early) return E_UNDEF;
      if (!iface_en[1])          return E_UNDEF;
      if (rt)                    return dbg_undef_late ? E_UNDEF : E_TRAP3;
      return E_PHYS;
    end
    if (rt1 && dbg_undef_early)  return E_UNDEF;
    if (l2ok && cp_group_trap)   return E_TRAP2;
    if (!iface_en[0])            return E_UNDEF;
    if (l2ok && trap_all_g0)     return E_TRAP2;
    if (l2ok && fiq_virt)        return E_VIRT;
    if (rt1)                     return dbg_undef_late ? E_UNDEF : E_TRAP3;
    return E_PHYS;
  endfunction

  function automatic string pick_tag(logic [4:0] e);
    if (cur_lvl == 2'd0) return "R3";
    if (cur_lvl == 2'd3) return "R8";
    if (cur_lvl == 2'd2) return "R7";
    if (l3_narrow && in_monitor && has_l3 && fiq_route_l3) return "R6";
    if (!(has_l2 && l2_active) && (cp_group_trap || trap_all_g0 || fiq_virt)) return "R9";
    if (e == E_VIRT || e == E_TRAP3 || e == E_PHYS) return "R5";
    return "R4";
  endfunction

  task automatic check_vec(string tag, logic [4:0] exp_o, logic exp_w);
    logic [4:0] got;
    logic [5:0] exp_c;
    got = {res_undef, res_trap_l2, res_trap_l3, res_virt, res_phys};
    checks++;
    if (got !== exp_o) begin
      fails++;
      $display("FAIL %s outcome: got %b expected %b", tag, got, exp_o);
    end
    exp_c = (exp_o == E_TRAP2 || exp_o == E_TRAP3) ? 6'd3 : 6'd0;
    checks++;
    if (res_code !== exp_c) begin
      fails++;
      $display("FAIL R10 code: got %0d expected %0d", res_code, exp_c);
    end
    checks++;
    if (res_wr !== exp_w) begin
      fails++;
      $display("FAIL R11 direction: got %b expected %b", res_wr, exp_w);
    end
  endtask

  task automatic step_and_check(string tag, logic [4:0] exp_o);
    logic w;
    w = acc_wr;
    @(posedge clk);
    #1;
    check_vec(tag, exp_o, w);
  endtask

  initial begin
    // R12: reset clears everything even with a matching level-3 access pending
    repeat (3) @(posedge clk);
    #1;
    check_vec("R12", 5'b0, 1'b0);
    rst = 1'b0;

    // R2/R3..R9: every combination of level and control bits
    for (int v = 0; v < 65536; v++) begin
      cur_lvl         = v[1:0];
      has_l2          = v[2];
      l2_active       = v[3];
      has_l3          = v[4];
      l3_narrow       = v[5];
      in_monitor      = v[6];
      fiq_route_l3    = v[7];
      dbg_undef_early = v[8];
      dbg_undef_late  = v[9];
      cp_group_trap   = v[10];
      trap_all_g0     = v[11];
      fiq_virt        = v[12];
      iface_en        = v[15:13];
      acc_wr          = v[0] ^ v[5] ^ v[10];
      step_and_check(pick_tag(expect_outcome()), expect_outcome());
    end

    // R1: every other value of each field, with a physical-copy context
    cur_lvl = 2'd3; iface_en = 3'b111;
    for (int i = 0; i < 16; i++) begin
      acc_cp = 4'(i); acc_wr = i[0];
      step_and_check("R1", (i == 15) ? E_PHYS : 5'b0);
    end
    acc_cp = 4'd15;
    for (int i = 0; i < 8; i++) begin
      acc_opc1 = 3'(i); acc_wr = i[1];
      step_and_check("R1", (i == 0) ? E_PHYS : 5'b0);
    end
    acc_opc1 = 3'd0;
    for (int i = 0; i < 16; i++) begin
      acc_crn = 4'(i); acc_wr = i[0];
      step_and_check("R1", (i == 12) ? E_PHYS : 5'b0);
    end
    acc_crn = 4'd12;
    for (int i = 0; i < 16; i++) begin
      acc_crm = 4'(i); acc_wr = ~i[0];
      step_and_check("R1", (i == 8) ? E_PHYS : 5'b0);
    end
    acc_crm = 4'd8;
    for (int i = 0; i < 8; i++) begin
      acc_opc2 = 3'(i); acc_wr = i[2];
      step_and_check("R1", (i == 3) ? E_PHYS : 5'b0);
    end
    acc_opc2 = 3'd3;

    // R1: a miss at level 0 stays silent instead of reporting undefined
    cur_lvl = 2'd0; acc_crm = 4'd9;
    step_and_check("R1", 5'b0);
    acc_crm = 4'd8;
    step_and_check("R3", E_UNDEF);

    // R12: reset asserted mid-run clears a live result
    cur_lvl = 2'd3;
    step_and_check("R8", E_PHYS);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check_vec("R12", 5'b0, 1'b0);
    rst = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule